// File: doc/BRIEF.md
# Programmable Chip-Select Decoder With Wait States

This block sits beside a bus interface and turns each bus cycle's address and memory/I/O type into active-low chip-select lines. Four memory selects divide one mid-range memory block into quarters. Seven peripheral selects each cover a 128-byte window above a peripheral base address. The block also produces the internal ready that ends the cycle.

A control register sets several things:
- the memory block size;
- whether the peripheral selects answer I/O or memory cycles;
- whether the two highest peripheral select pins carry selects or the latched address bits A1/A2;
- the wait-state count and ready policy for the upper peripheral windows.

Two base registers place the memory block and the peripheral windows. No select fires until software has accessed all three registers.

A cycle begins when `start` is sampled high while the block is idle. The chosen select is registered at that edge and held until the cycle ends. The cycle ends on the clock edge that follows a cycle in which `rdy` is high.

Top module: `csdec`

## Requirements
- R1: After reset every output of `mcs_n` and `pcs_n` is high, and the control register reads 16'h0003. A register is accessed by a read or a write at `reg_addr` 0 (control), 1 (memory base) or 2 (peripheral base). Until all three have been accessed, no select asserts, and every cycle is a plain cycle as in R8.
- R2: Control bits [11:5] hold the block size as one-hot: bit 5+n means 8 KB << n. The memory base register bits [6:0] hold address bits [19:13]. A memory cycle inside the block asserts `mcs_n[q]`, where q is the quarter of the block that holds the address. If the address lies in both regions, the memory region wins.
- R3: Peripheral base register bits [9:0] hold address bits [19:10]. An address at offset w*128 to w*128+127 above that base asserts peripheral select w for w = 0..6. Offsets 896..1023 select nothing.
- R4: Control bit 3 clear makes the peripheral selects answer only I/O cycles (`mio`=0). Set, they answer only memory cycles (`mio`=1). Memory selects answer only memory cycles.
- R5: Control bit 4 set makes `pcs5_pin`/`pcs6_pin` carry peripheral selects 5 and 6. Clear, they carry address bit 1 and address bit 2, latched at cycle start.
- R6: For a cycle hitting window 4, 5 or 6 with control bit 2 clear, `rdy` first rises after max(W, D) busy cycles. W is control bits [1:0]. D is the number of busy cycles before `ext_rdy` goes high.
- R7: For a cycle hitting window 4, 5 or 6 with control bit 2 set, `rdy` rises after exactly W busy cycles, whatever `ext_rdy` does.
- R8: Any other cycle has zero wait states, and `rdy` follows `ext_rdy`.
- R9: The selects hold their value from the first busy cycle through the ready cycle, even if the address changes. They all return high on the following cycle.
- R10: Control bits [15:12], memory base bits [15:7] and peripheral base bits [15:10] ignore writes and read back as zero.
- R11: A block-size field that is not one-hot asserts no memory select.
- R12: `start` is ignored while a cycle is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 20 | Bus address |
| mio | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| start | input | 1 | Cycle-start pulse |
| ext_rdy | input | 1 | External ready |
| reg_addr | input | 2 | Register select: 0 control, 1 memory base, 2 peripheral base |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational on `reg_addr` |
| mcs_n | output | 4 | Memory chip selects, active low |
| pcs_n | output | 5 | Peripheral chip selects 0..4, active low |
| pcs5_pin | output | 1 | Peripheral select 5 or latched A1 |
| pcs6_pin | output | 1 | Peripheral select 6 or latched A2 |
| rdy | output | 1 | Internal ready, ends the current cycle |

## Verification
A wrong internal state shows up within one cycle of it arising:
- A bad decode index or a stale lockout flag asserts the wrong select line, or none. This is visible in the first busy cycle.
- A mis-loaded or mis-decremented wait counter moves the `rdy` pulse earlier or later by whole cycles. Each cycle's ready position is compared against max(W, D), W or D.
- A busy flag that fails to clear leaves a select low in the cycle after ready.
- A wrong latch of the address bits shows on the shared pins once the address moves mid-cycle.

// File: rtl/csdec.sv
module csdec (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [19:0] addr,
  input  logic        mio,
  input  logic        start,
  input  logic        ext_rdy,
  input  logic [1:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic [3:0]  mcs_n,
  output logic [4:0]  pcs_n,
  output logic        pcs5_pin,
  output logic        pcs6_pin,
  output logic        rdy
);
  logic [11:0] ctrl_q;
  logic [6:0]  mbase_q;
  logic [9:0]  pbase_q;
  logic [2:0]  seen_q;
  logic [3:0]  mcs_q;
  logic [6:0]  pcs_q;
  logic [1:0]  la_q;
  logic [1:0]  cnt_q;
  logic        busy_q, grp_q;

  wire [1:0] wcnt   = ctrl_q[1:0];
  wire       rdis   = ctrl_q[2];
  wire       pmem   = ctrl_q[3];
  wire       pinsel = ctrl_q[4];
  wire [6:0] blk    = ctrl_q[11:5];
  wire       armed  = &seen_q;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {4'b0, ctrl_q};
      2'd1:    reg_rdata = {9'b0, mbase_q};
      2'd2:    reg_rdata = {6'b0, pbase_q};
      default: reg_rdata = 16'h0;
    endcase
  end

  logic       mhit;
  logic [1:0] midx;
  always_comb begin
    mhit = 1'b0;
    midx = 2'd0;
    for (int n = 0; n < 7; n++) begin
      if (blk == 7'(1 << n)) begin
        if (((addr ^ {mbase_q, 13'b0}) & ~((20'h2000 << n) - 20'd1)) == 20'd0) begin
          mhit = mio;
          midx = addr[11+n +: 2];
        end
      end
    end
  end

  wire [2:0] pidx = addr[9:7];
  wire       pwin = (addr[19:10] == pbase_q) && (mio == pmem) && (pidx != 3'd7);

  logic [3:0] msel;
  logic [6:0] psel;
  logic       grp;
  always_comb begin
    msel = '0;
    psel = '0;
    grp  = 1'b0;
    if (armed) begin
      if (mhit) msel[midx] = 1'b1;
      else if (pwin) begin
        grp = (pidx >= 3'd4);
        if (pidx < 3'd5 || pinsel) psel[pidx] = 1'b1;
      end
    end
  end

  assign rdy = busy_q && (cnt_q == 2'd0) && (ext_rdy || (grp_q && rdis));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= 12'h003;
      mbase_q <= '0;
      pbase_q <= '0;
      seen_q  <= '0;
    end else begin
      if ((reg_wr || reg_rd) && reg_addr != 2'd3) seen_q[reg_addr] <= 1'b1;
      if (reg_wr) begin
        case (reg_addr)
          2'd0:    ctrl_q  <= reg_wdata[11:0];
          2'd1:    mbase_q <= reg_wdata[6:0];
          2'd2:    pbase_q <= reg_wdata[9:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      grp_q  <= 1'b0;
      cnt_q  <= '0;
      mcs_q  <= '1;
      pcs_q  <= '1;
      la_q   <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        grp_q  <= grp;
        cnt_q  <= grp ? wcnt : 2'd0;
        mcs_q  <= ~msel;
        pcs_q  <= ~psel;
        la_q   <= addr[2:1];
      end
    end else if (rdy) begin
      busy_q <= 1'b0;
      mcs_q  <= '1;
      pcs_q  <= '1;
    end else if (cnt_q != 2'd0) begin
      cnt_q <= cnt_q - 2'd1;
    end
  end

  assign mcs_n    = mcs_q;
  assign pcs_n    = pcs_q[4:0];
  assign pcs5_pin = pinsel ? pcs_q[5] : la_q[0];
  assign pcs6_pin = pinsel ? pcs_q[6] : la_q[1];

  AST_SEL_ONEHOT:  assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~{pcs_q, mcs_q})); // R2
  AST_LOCKOUT:     assert property (@(posedge clk) disable iff (!rst_n) !armed |-> (&{pcs_q, mcs_q})); // R1
  AST_SEL_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) busy_q && !rdy |=> $stable({pcs_q, mcs_q})); // R9
  AST_SEL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) busy_q && rdy |=> (&{pcs_q, mcs_q}) && !busy_q); // R9
  AST_EXT_NEEDED:  assert property (@(posedge clk) disable iff (!rst_n) rdy && !(grp_q && rdis) |-> ext_rdy); // R6
  AST_IDLE_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n) !busy_q |-> (&{pcs_q, mcs_q}) && !rdy); // R12
endmodule

// File: tb/csdec_bench.sv
module csdec_bench;
  logic        clk = 0, rst_n = 0;
  logic [19:0] addr = 0;
  logic        mio = 0, start = 0, ext_rdy = 0;
  logic [1:0]  reg_addr = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic [3:0]  mcs_n;
  logic [4:0]  pcs_n;
  logic        pcs5_pin, pcs6_pin, rdy;

  int checks = 0, fails = 0;
  int seed = 12345;
  logic [11:0] b_ctrl;
  logic [6:0]  b_mb;
  logic [9:0]  b_pb;
  logic [2:0]  b_seen;

  csdec u_csdec (.clk(clk), .rst_n(rst_n), .addr(addr), .mio(mio), .start(start), .ext_rdy(ext_rdy),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mcs_n(mcs_n), .pcs_n(pcs_n), .pcs5_pin(pcs5_pin), .pcs6_pin(pcs6_pin), .rdy(rdy));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr = 1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    b_seen[a] = 1'b1;
    case (a)
      2'd0: b_ctrl = d[11:0];
      2'd1: b_mb   = d[6:0];
      2'd2: b_pb   = d[9:0];
      default: ;
    endcase
  endtask

  // returns {grp, pin6, pin5, pcs[4:0], mcs[3:0]}
  function automatic logic [11:0] model(input logic [19:0] a, input logic m);
    logic [10:0] o;
    logic        g;
    int          sz, base, pb, w;
    bit          hit;
    o = 11'h7FF; g = 0; hit = 0;
    if (b_seen == 3'b111) begin
      for (int n = 0; n < 7; n++) begin
        if (b_ctrl[11:5] == 7'(1 << n) && m) begin
          sz = 32'h2000 << n;
          base = int'(b_mb) << 13;
          if (int'(a) >= base && int'(a) < base + sz) begin
            o[(int'(a) - base) / (sz / 4)] = 1'b0;
            hit = 1;
          end
        end
      end
      pb = int'(b_pb) << 10;
      if (!hit && m == b_ctrl[3] && int'(a) >= pb && int'(a) < pb + 896) begin
        w = (int'(a) - pb) / 128;
        g = (w >= 4);
        o[4 + w] = 1'b0;
      end
    end
    if (!b_ctrl[4]) begin
      o[9]  = a[1];
      o[10] = a[2];
    end
    return {g, o};
  endfunction

  task automatic run_cycle(input logic [19:0] a, input logic m, input int d, input string tag);
    logic [11:0] e;
    int          expk, k;
    bit          found;
    e = model(a, m);
    if (e[11]) expk = b_ctrl[2] ? int'(b_ctrl[1:0]) : ((d > int'(b_ctrl[1:0])) ? d : int'(b_ctrl[1:0]));
    else expk = d;
    @(negedge clk);
    addr = a; mio = m; start = 1; ext_rdy = 0;
    @(negedge clk);
    start = 1;   // a start while busy must be ignored (R12)
    k = 0; found = 0;
    while (!found && k < 20) begin
      ext_rdy = (k >= d);
      if (k == 1) addr = 20'($urandom);
      #1;
      chk({pcs6_pin, pcs5_pin, pcs_n, mcs_n} == e[10:0], {tag, " R9 select"},
          {pcs6_pin, pcs5_pin, pcs_n, mcs_n}, e[10:0]);
      if (rdy) found = 1;
      else begin
        @(negedge clk);
        k++;
      end
    end
    chk(found && k == expk, {tag, " wait"}, k, expk);
    start = 0;
    @(negedge clk);
    #1;
    chk({pcs_n, mcs_n} == 9'h1FF && !rdy, "R9 release/R12", {rdy, pcs_n, mcs_n}, 10'h1FF);
    ext_rdy = 0;
  endtask

  function automatic logic [19:0] pick(input int mode);
    int sz;
    sz = 0;
    for (int n = 0; n < 7; n++) if (b_ctrl[11:5] == 7'(1 << n)) sz = 32'h2000 << n;
    if (mode == 0 && sz != 0) return 20'((int'(b_mb) << 13) + int'($urandom % sz));
    if (mode <= 1) return 20'((int'(b_pb) << 10) + int'($urandom % 1024));
    return 20'($urandom);
  endfunction

  initial begin
    int n;
    logic [11:0] e;
    b_ctrl = 12'h003; b_mb = 0; b_pb = 0; b_seen = 0;
    void'($urandom(seed));
    #45 rst_n = 1;
    @(negedge clk); #1;
    chk({pcs_n, mcs_n} == 9'h1FF && !rdy, "R1 reset selects", {rdy, pcs_n, mcs_n}, 10'h1FF);
    reg_addr = 0; reg_rd = 1; #1;
    chk(reg_rdata == 16'h0003, "R1 ctrl reset", reg_rdata, 16'h0003);
    @(negedge clk); reg_rd = 0; b_seen[0] = 1;

    // lockout: memory base only, peripheral base untouched
    wreg(1, 16'h0010);
    wreg(0, 16'h0FFF & {4'h0, 7'h01, 1'b1, 1'b1, 1'b0, 2'd0});
    run_cycle(20'h20000, 1'b1, 2, "R1 locked");
    run_cycle(20'h00080, 1'b1, 1, "R1 locked periph");

    // reserved bits and a non one-hot block size
    wreg(0, 16'hFFFF);
    reg_addr = 0; #1;
    chk(reg_rdata == 16'h0FFF, "R10 ctrl reserved", reg_rdata, 16'h0FFF);
    wreg(1, 16'hFFFF);
    reg_addr = 1; #1;
    chk(reg_rdata == 16'h007F, "R10 mbase reserved", reg_rdata, 16'h007F);
    wreg(2, 16'hFC08);
    reg_addr = 2; #1;
    chk(reg_rdata == 16'h0008, "R10 pbase reserved", reg_rdata, 16'h0008);
    wreg(1, 16'h0010);
    run_cycle(20'h20800, 1'b1, 0, "R11 invalid size");

    // block 8 KB at 0x20000: quarter 1 (R2), ready-disable set W=3 D=5 (R7 on window 4)
    wreg(0, {4'h0, 7'h01, 1'b1, 1'b0, 1'b1, 2'd3});
    run_cycle(20'h20900, 1'b1, 1, "R2 quarter1");
    run_cycle(20'h21F00, 1'b1, 0, "R2 quarter3");
    run_cycle(20'h02200, 1'b0, 5, "R7 exact W3");
    // ready-disable clear, W=2
    wreg(0, {4'h0, 7'h01, 1'b1, 1'b0, 1'b0, 2'd2});
    run_cycle(20'h02200, 1'b0, 5, "R6 ext late");
    run_cycle(20'h02300, 1'b0, 0, "R6 ext early");
    run_cycle(20'h02080, 1'b0, 3, "R3 window1 R8");
    run_cycle(20'h02380, 1'b0, 0, "R3 offset 896");
    run_cycle(20'h02080, 1'b1, 0, "R4 memory cycle to io window");
    // pins as address bits, window 6 still keeps group timing
    wreg(0, {4'h0, 7'h01, 1'b0, 1'b1, 1'b1, 2'd1});
    run_cycle(20'h02306, 1'b1, 4, "R5 latched A2A1");
    run_cycle(20'h02282, 1'b1, 0, "R4 memory-type periph");

    // random
    for (int i = 0; i < 300; i++) begin
      if (i % 25 == 0) begin
        n = $urandom % 7;
        wreg(1, 16'(($urandom & 7'h7F) & ~((1 << n) - 1)));
        wreg(2, 16'($urandom));
        wreg(0, {4'h0, 7'(1 << n), 5'($urandom)});
      end
      e = 0;
      run_cycle(pick($urandom % 3), 1'($urandom), $urandom % 6, "R2/R3/R5 random");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #3000000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule